// File: doc/BRIEF.md
# Diagnostic Register Bank with Split 64-bit Access

This block sits in a device's 8 KiB memory-mapped register window and holds a handful of registers that software uses to check its own access paths. There are two test registers, one 32 bits wide and one 64 bits wide. Each reads back double the value last written to it, so a driver can tell a real register access from a bus that merely echoes data. An interrupt test register turns a written number into a one-cycle request to the interrupt block to raise that single vector. A group of plain read/write registers holds a DMA address, a transfer size and a control word.

A 64-bit register can be written with one 8-byte transfer. It can also be written as two 4-byte transfers, low half first. The low half waits in a shadow and the whole value changes only when the high half arrives. A high half written with no low half pending is discarded and sets a sticky error output. The host port is a valid/ready request with a one-cycle response. A bus sequencer with two states, `ST_IDLE` and `ST_RESP`, accepts one request in `ST_IDLE` and returns its response in `ST_RESP`. The transition `ST_IDLE -> ST_RESP` is taken on acceptance and `ST_RESP -> ST_IDLE` is taken always.

Top module: `diag_regbank`

## Requirements
- R1: `req_ready` is 1 exactly in the cycles where no response is being given. A request is accepted when `req_valid` and `req_ready` are both 1 at a rising edge, and `rsp_valid` is then 1 for exactly the following cycle. The response to a write carries `rsp_rdata` = 0.
- R2: The 32-bit test register sits at offset 0x010 (4-byte access, `req_size8` = 0). A read returns twice the last written value modulo 2^32 in `rsp_rdata[31:0]`, with the upper 32 bits zero. 4-byte writes use `req_wdata[31:0]`.
- R3: The 64-bit test register sits at offset 0x018. An 8-byte read (`req_size8` = 1) returns twice the stored value modulo 2^64. A 4-byte read at 0x018 returns the low 32 bits of that doubled value and one at 0x01C returns its high 32 bits.
- R4: A 4-byte write to the low half (0x018 or 0x028) changes no readable value. A following 4-byte write to the high half (0x01C or 0x02C) commits {high data, held low data} in one step.
- R5: A 4-byte write to a high half with no low half pending leaves the register unchanged. It sets `split_err`, which stays 1 until reset.
- R6: An 8-byte write to a 64-bit register commits the whole value at once and discards any pending low half. A later high-half-only write is then treated as in R5.
- R7: A 4-byte write of N to offset 0x020 with N < 256 drives `irq_set_valid` = 1 with `irq_set_vec` = N for exactly the response cycle. N >= 256 raises nothing. A read of 0x020 returns the last written value unchanged, and reads never raise a request.
- R8: The DMA address register is at 0x028 (64-bit, split access as in R4), the DMA size register at 0x030 and the DMA control register at 0x034 (32-bit). All read back exactly the value written, with no doubling.
- R9: Any other offset, misaligned offset or width mismatch (8-byte access to a 32-bit register, or 4-byte access at 0x020+4) reads 0, and a write there changes no register.
- R10: After reset every register reads 0, `split_err` = 0, `irq_set_valid` = 0, `rsp_valid` = 0 and `req_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Byte offset inside the window |
| req_size8 | input | 1 | 1 = 8-byte transfer, 0 = 4-byte transfer |
| req_wdata | input | 64 | Write data (4-byte transfers use bits 31:0) |
| rsp_valid | output | 1 | Response cycle |
| rsp_rdata | output | 64 | Read data, 0 for writes |
| irq_set_valid | output | 1 | One-cycle request to set a pending vector |
| irq_set_vec | output | 8 | Vector number for that request |
| split_err | output | 1 | Sticky: a high half arrived with no low half pending |

## Verification
Two functions meet in a single write cycle: the commit of a full-width 8-byte write and the dropping of a low half still waiting in the shadow. The bench provokes this by placing a low-half write to the DMA address register directly before an 8-byte write to the same register. It then sends a high-half-only write. The 8-byte value must read back untouched, because the shadow must have been emptied by the full write. A second overlap is the vector request and the write response, which fall in the same cycle. The scoreboard checks both together on every response.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_state_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_T32,
        SEL_T64,
        SEL_IRQ,
        SEL_DADDR,
        SEL_DSIZE,
        SEL_DCTRL
    } reg_sel_t;

    typedef enum logic [1:0] {
        PART_FULL,
        PART_LO,
        PART_HI
    } part_t;

    localparam int unsigned OFF_T32   = 32'h0010;
    localparam int unsigned OFF_T64   = 32'h0018;
    localparam int unsigned OFF_IRQ   = 32'h0020;
    localparam int unsigned OFF_DADDR = 32'h0028;
    localparam int unsigned OFF_DSIZE = 32'h0030;
    localparam int unsigned OFF_DCTRL = 32'h0034;

endpackage

// File: rtl/diag_decode.sv
module diag_decode
    import diag_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              size8,
    output reg_sel_t          sel,
    output part_t             part
);
    localparam logic [ADDR_W-1:0] A_T32   = ADDR_W'(OFF_T32);
    localparam logic [ADDR_W-1:0] A_T64   = ADDR_W'(OFF_T64);
    localparam logic [ADDR_W-1:0] A_T64H  = ADDR_W'(OFF_T64 + 4);
    localparam logic [ADDR_W-1:0] A_IRQ   = ADDR_W'(OFF_IRQ);
    localparam logic [ADDR_W-1:0] A_DADDR = ADDR_W'(OFF_DADDR);
    localparam logic [ADDR_W-1:0] A_DADRH = ADDR_W'(OFF_DADDR + 4);
    localparam logic [ADDR_W-1:0] A_DSIZE = ADDR_W'(OFF_DSIZE);
    localparam logic [ADDR_W-1:0] A_DCTRL = ADDR_W'(OFF_DCTRL);

    always_comb begin
        sel  = SEL_NONE;
        part = PART_FULL;
        if (size8) begin
            if (addr == A_T64)        sel = SEL_T64;
            else if (addr == A_DADDR) sel = SEL_DADDR;
        end else begin
            if (addr == A_T32)        sel = SEL_T32;
            else if (addr == A_IRQ)   sel = SEL_IRQ;
            else if (addr == A_DSIZE) sel = SEL_DSIZE;
            else if (addr == A_DCTRL) sel = SEL_DCTRL;
            else if (addr == A_T64) begin
                sel  = SEL_T64;
                part = PART_LO;
            end else if (addr == A_T64H) begin
                sel  = SEL_T64;
                part = PART_HI;
            end else if (addr == A_DADDR) begin
                sel  = SEL_DADDR;
                part = PART_LO;
            end else if (addr == A_DADRH) begin
                sel  = SEL_DADDR;
                part = PART_HI;
            end
        end
    end
endmodule

// File: rtl/diag_wide_reg.sv
module diag_wide_reg
    import diag_pkg::*;
#(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  part_t        part,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] value,
    output logic         orphan
);
    localparam int HW = W / 2;

    logic [HW-1:0] shadow_q;
    logic          pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value    <= '0;
            shadow_q <= '0;
            pend_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (part)
                PART_FULL: begin
                    value  <= wdata;
                    pend_q <= 1'b0;
                end
                PART_LO: begin
                    shadow_q <= wdata[HW-1:0];
                    pend_q   <= 1'b1;
                end
                PART_HI: begin
                    if (pend_q) begin
                        value  <= {wdata[HW-1:0], shadow_q};
                        pend_q <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    assign orphan = wr_en && (part == PART_HI) && !pend_q;
endmodule

// File: rtl/diag_irq_req.sv
module diag_irq_req #(
    parameter int NUM_VEC = 256,
    parameter int VW      = 8,
    parameter int HW      = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [HW-1:0] value,
    output logic          irq_valid,
    output logic [VW-1:0] irq_vec
);
    localparam logic [HW-1:0] LIMIT = HW'(NUM_VEC);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_vec   <= '0;
        end else begin
            irq_valid <= fire && (value < LIMIT);
            if (fire) irq_vec <= value[VW-1:0];
        end
    end
endmodule

// File: rtl/diag_regbank.sv
module diag_regbank
    import diag_pkg::*;
#(
    parameter int WIN_BYTES = 8192,
    parameter int NUM_VEC   = 256,
    parameter int DATA_W    = 64,
    localparam int ADDR_W   = $clog2(WIN_BYTES),
    localparam int VEC_W    = $clog2(NUM_VEC),
    localparam int HALF_W   = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_size8,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_set_valid,
    output logic [VEC_W-1:0]  irq_set_vec,
    output logic              split_err
);
    localparam int NWIDE = 2;

    bus_state_t state_q, state_d;
    reg_sel_t   dec_sel, cap_sel;
    part_t      dec_part, cap_part;
    logic       cap_write;
    logic       accept, wr;

    logic [HALF_W-1:0] t32_q, irqv_q, dsize_q, dctrl_q;
    logic [DATA_W-1:0] wide_val [NWIDE];
    logic [NWIDE-1:0]  wide_orphan;
    logic [DATA_W-1:0] rd_mux;

    assign accept = req_valid && req_ready;
    assign wr     = accept && req_write;

    diag_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (req_addr),
        .size8 (req_size8),
        .sel   (dec_sel),
        .part  (dec_part)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_rdata = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_RESP: begin
                rsp_valid = 1'b1;
                rsp_rdata = cap_write ? '0 : rd_mux;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_sel   <= SEL_NONE;
            cap_part  <= PART_FULL;
            cap_write <= 1'b0;
        end else if (accept) begin
            cap_sel   <= dec_sel;
            cap_part  <= dec_part;
            cap_write <= req_write;
        end
    end

    // narrow registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t32_q   <= '0;
            irqv_q  <= '0;
            dsize_q <= '0;
            dctrl_q <= '0;
        end else if (wr) begin
            unique case (dec_sel)
                SEL_T32:   t32_q   <= req_wdata[HALF_W-1:0];
                SEL_IRQ:   irqv_q  <= req_wdata[HALF_W-1:0];
                SEL_DSIZE: dsize_q <= req_wdata[HALF_W-1:0];
                SEL_DCTRL: dctrl_q <= req_wdata[HALF_W-1:0];
                default: ;
            endcase
        end
    end

    // wide registers with split-access shadows
    for (genvar g = 0; g < NWIDE; g++) begin : g_wide
        localparam reg_sel_t MY_SEL = (g == 0) ? SEL_T64 : SEL_DADDR;
        diag_wide_reg #(.W(DATA_W)) u_wide (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr && (dec_sel == MY_SEL)),
            .part   (dec_part),
            .wdata  (req_wdata),
            .value  (wide_val[g]),
            .orphan (wide_orphan[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) split_err <= 1'b0;
        else if (|wide_orphan) split_err <= 1'b1;
    end

    diag_irq_req #(.NUM_VEC(NUM_VEC), .VW(VEC_W), .HW(HALF_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (wr && (dec_sel == SEL_IRQ)),
        .value     (req_wdata[HALF_W-1:0]),
        .irq_valid (irq_set_valid),
        .irq_vec   (irq_set_vec)
    );

    // read mux
    logic [HALF_W-1:0] t32_dbl;
    logic [DATA_W-1:0] t64_dbl;
    assign t32_dbl = {t32_q[HALF_W-2:0], 1'b0};
    assign t64_dbl = {wide_val[0][DATA_W-2:0], 1'b0};

    function automatic logic [DATA_W-1:0] pick(input logic [DATA_W-1:0] v, input part_t p);
        unique case (p)
            PART_LO: pick = {{HALF_W{1'b0}}, v[HALF_W-1:0]};
            PART_HI: pick = {{HALF_W{1'b0}}, v[DATA_W-1:HALF_W]};
            default: pick = v;
        endcase
    endfunction

    always_comb begin
        rd_mux = '0;
        unique case (cap_sel)
            SEL_T32:   rd_mux = {{HALF_W{1'b0}}, t32_dbl};
            SEL_T64:   rd_mux = pick(t64_dbl, cap_part);
            SEL_IRQ:   rd_mux = {{HALF_W{1'b0}}, irqv_q};
            SEL_DADDR: rd_mux = pick(wide_val[1], cap_part);
            SEL_DSIZE: rd_mux = {{HALF_W{1'b0}}, dsize_q};
            SEL_DCTRL: rd_mux = {{HALF_W{1'b0}}, dctrl_q};
            default:   rd_mux = '0;
        endcase
    end
endmodule

// File: rtl/diag_regbank_chk.sv
module diag_regbank_chk #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 64,
    parameter int VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_size8,
    input logic [DATA_W-1:0] req_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              irq_set_valid,
    input logic [VEC_W-1:0]  irq_set_vec,
    input logic              split_err
);
    localparam int HW = DATA_W / 2;

    // R1
    accept_gives_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R1
    rsp_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R1
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    irq_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_valid |-> $past(req_valid && req_ready && req_write && !req_size8
                                && req_addr == ADDR_W'(32'h20)));

    // R7
    irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set_valid |-> (irq_set_vec == $past(req_wdata[VEC_W-1:0])));

    // R5
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        split_err |=> split_err);

    // R2
    t32_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_valid && req_ready && !req_write && !req_size8
                            && req_addr == ADDR_W'(32'h10)))
        |-> (rsp_rdata[0] == 1'b0 && rsp_rdata[DATA_W-1:HW] == '0));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(req_valid && req_ready && !req_write
                            && req_addr >= ADDR_W'(32'h40)))
        |-> (rsp_rdata == '0));
endmodule

bind diag_regbank diag_regbank_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size8(req_size8),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_set_valid(irq_set_valid), .irq_set_vec(irq_set_vec),
    .split_err(split_err)
);

// File: tb/diag_regbank_tb.sv
`timescale 1ns/1ps
module diag_regbank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [12:0] req_addr = '0;
    logic        req_size8 = 1'b0;
    logic [63:0] req_wdata = '0;
    logic        req_ready, rsp_valid, irq_set_valid, split_err;
    logic [63:0] rsp_rdata;
    logic [7:0]  irq_set_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] rd;
        bit          irq;
        logic [7:0]  vec;
        string       rq;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    diag_regbank u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size8(req_size8),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .irq_set_valid(irq_set_valid), .irq_set_vec(irq_set_vec),
        .split_err(split_err)
    );

    task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // driver: pushes the expected response, then presents the request
    task automatic access(input bit w, input logic [12:0] a, input bit s8, input logic [63:0] wd,
                          input logic [63:0] exp_rd, input bit exp_irq, input logic [7:0] exp_vec,
                          input string rq);
        exp_t e;
        e.rd = exp_rd; e.irq = exp_irq; e.vec = exp_vec; e.rq = rq;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        sbq.push_back(e);
        req_valid = 1'b1; req_write = w; req_addr = a; req_size8 = s8; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = '0;
    endtask

    task automatic wr4(input logic [12:0] a, input logic [31:0] d, input string rq);
        access(1'b1, a, 1'b0, {32'h0, d}, 64'h0, 1'b0, 8'h0, rq);
    endtask
    task automatic wr8(input logic [12:0] a, input logic [63:0] d, input string rq);
        access(1'b1, a, 1'b1, d, 64'h0, 1'b0, 8'h0, rq);
    endtask
    task automatic rd4(input logic [12:0] a, input logic [31:0] e, input string rq);
        access(1'b0, a, 1'b0, 64'h0, {32'h0, e}, 1'b0, 8'h0, rq);
    endtask
    task automatic rd8(input logic [12:0] a, input logic [63:0] e, input string rq);
        access(1'b0, a, 1'b1, 64'h0, e, 1'b0, 8'h0, rq);
    endtask
    task automatic irqw(input logic [31:0] n, input bit fires, input string rq);
        access(1'b1, 13'h020, 1'b0, {32'h0, n}, 64'h0, fires, n[7:0], rq);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R1 unexpected response", rsp_rdata, 64'h0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(rsp_rdata == e.rd, e.rq, rsp_rdata, e.rd);
                    chk(irq_set_valid == e.irq && (!e.irq || irq_set_vec == e.vec),
                        {e.rq, " R7 irq"}, {55'h0, irq_set_valid, irq_set_vec},
                        {55'h0, e.irq, e.vec});
                    chk(!req_ready, "R1 ready low in response", {63'h0, req_ready}, 64'h0);
                end
            end else if (irq_set_valid) begin
                chk(1'b0, "R7 irq outside response", {56'h0, irq_set_vec}, 64'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(req_ready && !rsp_valid && !irq_set_valid && !split_err, "R10 reset outputs",
            {60'h0, req_ready, rsp_valid, irq_set_valid, split_err}, 64'h8);
        rd4(13'h010, 32'h0, "R10 t32 reset");
        rd8(13'h018, 64'h0, "R10 t64 reset");
        rd8(13'h028, 64'h0, "R10 daddr reset");

        // R2 doubling 32-bit
        wr4(13'h010, 32'h1234_5678, "R1 write rsp zero");
        rd4(13'h010, 32'h2468_ACF0, "R2 t32 doubled");
        wr4(13'h010, 32'h8000_0001, "R2 write");
        rd4(13'h010, 32'h0000_0002, "R2 t32 wrap");

        // R3 doubling 64-bit
        wr8(13'h018, 64'h8000_0000_0000_0003, "R3 write");
        rd8(13'h018, 64'h0000_0000_0000_0006, "R3 t64 wrap");
        wr8(13'h018, 64'h0123_4567_89AB_CDEF, "R3 write");
        rd8(13'h018, 64'h0246_8ACF_1357_9BDE, "R3 t64 doubled");
        rd4(13'h018, 32'h1357_9BDE, "R3 low half read");
        rd4(13'h01C, 32'h0246_8ACF, "R3 high half read");

        // R4 split write
        wr4(13'h018, 32'h1111_1111, "R4 low half");
        rd8(13'h018, 64'h0246_8ACF_1357_9BDE, "R4 no change after low");
        wr4(13'h01C, 32'h2222_2222, "R4 high half");
        rd8(13'h018, 64'h4444_4444_2222_2222, "R4 committed");

        // R5 orphan high half
        @(negedge clk);
        chk(!split_err, "R5 err clear before", {63'h0, split_err}, 64'h0);
        wr4(13'h01C, 32'h0000_5555, "R5 orphan write");
        rd8(13'h018, 64'h4444_4444_2222_2222, "R5 orphan ignored");
        @(negedge clk);
        chk(split_err, "R5 err set", {63'h0, split_err}, 64'h1);

        // R6 full write discards pending shadow
        wr4(13'h028, 32'hAAAA_0000, "R6 low pending");
        wr8(13'h028, 64'h0000_00FF_0000_0010, "R6 full write");
        wr4(13'h02C, 32'h0000_0007, "R6 orphan after full");
        rd8(13'h028, 64'h0000_00FF_0000_0010, "R6 value kept");

        // R8 DMA registers
        wr4(13'h028, 32'hDEAD_BEEF, "R8 daddr low");
        wr4(13'h02C, 32'hCAFE_F00D, "R8 daddr high");
        rd8(13'h028, 64'hCAFE_F00D_DEAD_BEEF, "R8 daddr readback");
        rd4(13'h02C, 32'hCAFE_F00D, "R8 daddr high read");
        wr4(13'h030, 32'h0000_1000, "R8 size write");
        wr4(13'h034, 32'h0000_0003, "R8 ctrl write");
        rd4(13'h030, 32'h0000_1000, "R8 size readback");
        rd4(13'h034, 32'h0000_0003, "R8 ctrl readback");

        // R7 interrupt test register
        irqw(32'h3, 1'b1, "R7 vec 3");
        rd4(13'h020, 32'h3, "R7 readback");
        irqw(32'hFF, 1'b1, "R7 vec 255");
        irqw(32'h100, 1'b0, "R7 vec 256 none");
        rd4(13'h020, 32'h100, "R7 readback 256");

        // R9 unmapped and mismatched accesses
        wr4(13'h040, 32'hFFFF, "R9 unmapped write");
        rd4(13'h040, 32'h0, "R9 unmapped read");
        rd4(13'h1FFC, 32'h0, "R9 top of window");
        rd8(13'h010, 64'h0, "R9 8-byte on 32-bit reg");
        wr8(13'h010, 64'hFFFF_FFFF_FFFF_FFFF, "R9 8-byte write dropped");
        rd4(13'h010, 32'h0000_0002, "R9 t32 unchanged");
        wr4(13'h014, 32'h7777, "R9 misaligned write");
        rd4(13'h014, 32'h0, "R9 misaligned read");
        rd4(13'h024, 32'h0, "R9 irq+4 read");

        repeat (4) @(negedge clk);
        chk(sbq.size() == 0, "R1 all responses seen", 64'(sbq.size()), 64'h0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule